// File: doc/BRIEF.md
# Reference-Counted Physical Register Reclaimer

This block tracks which physical registers a core still needs. It keeps a grid of holder bits, with one column per physical register and one row per holder. A holder is anything that can keep a register alive, such as an in-flight instruction slot or the committed map table. A register returns to the pool on its own once every row has dropped its bit in that register's column. Nothing is ever pushed back onto a queue, so the allocator may hand out any free register in any order.

Each cycle the block accepts one set request and one clear request, each given as a row number and a binary register index. It also offers one destination register for dispatch. The grant marks the register as held by the requesting row at the next clock edge. The free vector shown at the ports already excludes the register granted in the current cycle.

A single checkpoint slot stores a snapshot of which registers are held. Restoring it trims every row down to that snapshot. This releases registers claimed after the snapshot, while registers released since the snapshot stay free. Physical register 0 backs the zero register. It is permanently held and is never offered.

Top module: `prc_reclaimer`

## Requirements
- R1: After a synchronous active-low reset, no row holds any register: `free_vec` shows every bit set except bit 0, and `alloc_idx` is 1.
- R2: A valid set request with row e and index p (1 <= p < NUM_PREGS) marks p as held by row e from the next cycle, clearing `free_vec[p]`.
- R3: A register reads as free only when no row holds it: clearing one holder's bit leaves the register busy while any other row still holds it.
- R4: When a set and a clear name the same row and the same index in one cycle, the set wins and the row still holds the register afterwards.
- R5: `alloc_valid` is high when some register other than 0 is free and no restore is under way. `alloc_idx` is then the lowest-numbered such register. A request in that cycle makes row `alloc_row` hold it from the next cycle.
- R6: In a cycle where a request is granted, `free_vec` already shows the granted register as not free.
- R7: When no register is free, `alloc_valid` is low and an allocation request changes nothing.
- R8: Register 0 is never shown free and never granted. Set and clear requests with index 0 have no effect.
- R9: A `ckpt_take` pulse stores the held vector that results from that cycle's updates. A take in the same cycle as a restore is ignored.
- R10: A `ckpt_restore` cycle ANDs every row with the stored held vector before applying that cycle's clear and set requests. Registers claimed after the snapshot become free, and registers freed since the snapshot stay free.
- R11: During a restore cycle `alloc_valid` is low and any allocation request is ignored.
- R12: Set and clear requests with an index at or above NUM_PREGS have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_valid | input | 1 | Set request valid |
| set_row | input | ROW_W | Row that takes the register |
| set_idx | input | IDX_W | Register index to mark held |
| clr_valid | input | 1 | Clear request valid |
| clr_row | input | ROW_W | Row that drops the register |
| clr_idx | input | IDX_W | Register index to release |
| alloc_req | input | 1 | Dispatch wants a destination register |
| alloc_row | input | ROW_W | Row that will hold the granted register |
| alloc_valid | output | 1 | A register can be granted this cycle |
| alloc_idx | output | IDX_W | Lowest free register index |
| free_vec | output | NUM_PREGS | Free bitvector, granted register masked |
| ckpt_take | input | 1 | Capture held-vector snapshot |
| ckpt_restore | input | 1 | Trim all rows to the snapshot |

## Verification
Some properties are checked on every cycle. Register 0 never reads free. A granted index is always free and becomes held at the next edge. An empty pool or a restore keeps `alloc_valid` low. A set request, including one that collides with a clear, always lands. After a restore, nothing outside the snapshot survives except freshly set registers. Other behaviour needs a sequence of cycles, so only the bench scenarios can show it. These cover lowest-index ordering, release only after the last holder drops its bit, exhaustion of the pool, ignored indices, and the snapshot-then-trim sequence. The bench compares every output against a reference model of the grid.

// File: rtl/prc_pkg.sv
// Package: default sizes shared by the reclaimer and its bench.
// Assumes nothing; pure constants.
package prc_pkg;
    localparam int PREG_COUNT_DEF = 160;
    localparam int ROW_COUNT_DEF  = 8;
endpackage

// File: rtl/prc_decoder.sv
// Turns a valid binary register index into a one-hot column mask.
// Assumes index 0 is the permanently held zero register: it never decodes.
// Indices at or above N decode to an all-zero mask.
module prc_decoder #(
    parameter int N     = 160,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             valid,
    input  logic [IDX_W-1:0] idx,
    output logic [N-1:0]     onehot
);
    assign onehot[0] = 1'b0;
    for (genvar p = 1; p < N; p++) begin : g_col
        // one comparator per column
        assign onehot[p] = valid && (idx == IDX_W'(p));
    end
endmodule

// File: rtl/prc_prio_enc.sv
// Finds the lowest set bit of a vector.
// Assumes the caller masks out any bit that must not be picked.
module prc_prio_enc #(
    parameter int N     = 160,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // scan from the top so the lowest set bit is the last one written
    always_comb begin
        idx = '0;
        for (int p = N - 1; p >= 0; p--) begin
            if (vec[p]) idx = IDX_W'(p);
        end
    end

    assign found = |vec;
endmodule

// File: rtl/prc_matrix.sv
// Holder grid: one row per holder, one column per physical register.
// Each row applies the restore trim first, then its clear mask, then its
// set masks, so a set beats a clear on the same bit.
// Assumes the one-hot masks never have bit 0 set.
module prc_matrix #(
    parameter int N     = 160,
    parameter int ROWS  = 8,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] set_row,
    input  logic [N-1:0]     set_oh,
    input  logic [ROW_W-1:0] clr_row,
    input  logic [N-1:0]     clr_oh,
    input  logic [ROW_W-1:0] grant_row,
    input  logic [N-1:0]     grant_oh,
    input  logic             restore,
    input  logic [N-1:0]     keep_mask,
    output logic [N-1:0]     held,
    output logic [N-1:0]     held_next
);
    logic [N-1:0] row_q [ROWS];
    logic [N-1:0] row_d [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [N-1:0] base;
        logic [N-1:0] setm;
        logic [N-1:0] clrm;

        // next-state of one row: trim, clear, then set
        always_comb begin
            base = restore ? (row_q[r] & keep_mask) : row_q[r];
            setm = ((set_row == ROW_W'(r)) ? set_oh : '0)
                 | ((grant_row == ROW_W'(r)) ? grant_oh : '0);
            clrm = (clr_row == ROW_W'(r)) ? clr_oh : '0;
            row_d[r] = (base & ~clrm) | setm;
        end

        // row storage with synchronous reset
        always_ff @(posedge clk) begin
            if (!rst_n) row_q[r] <= '0;
            else        row_q[r] <= row_d[r];
        end

        AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            ((set_row == ROW_W'(r)) && (set_oh != '0))
            |=> ((row_q[r] & $past(set_oh)) == $past(set_oh))); // R4
    end

    // column reduction of current and next state
    always_comb begin
        held      = '0;
        held_next = '0;
        for (int r = 0; r < ROWS; r++) begin
            held      = held | row_q[r];
            held_next = held_next | row_d[r];
        end
    end
endmodule

// File: rtl/prc_ckpt.sv
// Single-slot snapshot of the held vector.
// Assumes the caller supplies the held vector after this cycle's updates.
// A take that coincides with a restore is dropped.
module prc_ckpt #(
    parameter int N = 160
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic         restore,
    input  logic [N-1:0] held_next,
    output logic [N-1:0] keep_mask
);
    // capture the snapshot; reset value trims nothing
    always_ff @(posedge clk) begin
        if (!rst_n)                keep_mask <= '1;
        else if (take && !restore) keep_mask <= held_next;
    end

    AST_SNAPSHOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!take || restore) |=> $stable(keep_mask)); // R9
endmodule

// File: rtl/prc_reclaimer.sv
// Top: reference-counted physical register reclaimer.
// Derives the free vector from the holder grid, grants the lowest free
// register to dispatch and handles one checkpoint slot.
// Assumes register 0 is permanently held and never offered.
module prc_reclaimer
    import prc_pkg::*;
#(
    parameter int NUM_PREGS = PREG_COUNT_DEF,
    parameter int NUM_ROWS  = ROW_COUNT_DEF,
    parameter int IDX_W     = $clog2(NUM_PREGS),
    parameter int ROW_W     = $clog2(NUM_ROWS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_valid,
    input  logic [ROW_W-1:0]     set_row,
    input  logic [IDX_W-1:0]     set_idx,
    input  logic                 clr_valid,
    input  logic [ROW_W-1:0]     clr_row,
    input  logic [IDX_W-1:0]     clr_idx,
    input  logic                 alloc_req,
    input  logic [ROW_W-1:0]     alloc_row,
    output logic                 alloc_valid,
    output logic [IDX_W-1:0]     alloc_idx,
    output logic [NUM_PREGS-1:0] free_vec,
    input  logic                 ckpt_take,
    input  logic                 ckpt_restore
);
    logic [NUM_PREGS-1:0] set_oh, clr_oh, grant_oh;
    logic [NUM_PREGS-1:0] held, held_next, keep_mask, free_raw;
    logic                 any_free, grant;

    prc_decoder #(.N(NUM_PREGS), .IDX_W(IDX_W)) u_set_dec (
        .valid(set_valid), .idx(set_idx), .onehot(set_oh));
    prc_decoder #(.N(NUM_PREGS), .IDX_W(IDX_W)) u_clr_dec (
        .valid(clr_valid), .idx(clr_idx), .onehot(clr_oh));
    prc_decoder #(.N(NUM_PREGS), .IDX_W(IDX_W)) u_grant_dec (
        .valid(grant), .idx(alloc_idx), .onehot(grant_oh));

    prc_matrix #(.N(NUM_PREGS), .ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_matrix (
        .clk(clk), .rst_n(rst_n),
        .set_row(set_row), .set_oh(set_oh),
        .clr_row(clr_row), .clr_oh(clr_oh),
        .grant_row(alloc_row), .grant_oh(grant_oh),
        .restore(ckpt_restore), .keep_mask(keep_mask),
        .held(held), .held_next(held_next));

    prc_ckpt #(.N(NUM_PREGS)) u_ckpt (
        .clk(clk), .rst_n(rst_n), .take(ckpt_take), .restore(ckpt_restore),
        .held_next(held_next), .keep_mask(keep_mask));

    // NOR of each column, with the zero register forced busy
    always_comb begin
        free_raw    = ~held;
        free_raw[0] = 1'b0;
    end

    prc_prio_enc #(.N(NUM_PREGS), .IDX_W(IDX_W)) u_enc (
        .vec(free_raw), .found(any_free), .idx(alloc_idx));

    // offer only when something is free and no restore is in flight
    assign alloc_valid = any_free && !ckpt_restore;
    assign grant       = alloc_req && alloc_valid;
    assign free_vec    = free_raw & ~grant_oh;

    AST_ZERO_NEVER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !free_vec[0] && !(alloc_valid && alloc_idx == '0)); // R8
    AST_OFFER_IS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid |-> !held[alloc_idx]); // R5
    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && alloc_valid) |=> held[$past(alloc_idx)]); // R5
    AST_EMPTY_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (held[NUM_PREGS-1:1] == '1) |-> !alloc_valid); // R7
    AST_RESTORE_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_restore |-> !alloc_valid); // R11
    AST_RESTORE_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
        (ckpt_restore && !set_valid)
        |=> ((held & ~$past(keep_mask)) == '0)); // R10
endmodule

// File: tb/prc_reclaimer_tb.sv
module prc_reclaimer_tb_top;
    localparam int N     = 160;
    localparam int ROWS  = 8;
    localparam int IDX_W = $clog2(N);
    localparam int ROW_W = $clog2(ROWS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic set_valid = 1'b0, clr_valid = 1'b0, alloc_req = 1'b0;
    logic ckpt_take = 1'b0, ckpt_restore = 1'b0;
    logic [ROW_W-1:0] set_row = '0, clr_row = '0, alloc_row = '0;
    logic [IDX_W-1:0] set_idx = '0, clr_idx = '0;
    logic alloc_valid;
    logic [IDX_W-1:0] alloc_idx;
    logic [N-1:0] free_vec;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit last_valid;

    logic [N-1:0] m_rows [ROWS];
    logic [N-1:0] m_keep;

    always #5 clk = ~clk;

    prc_reclaimer dut_i (
        .clk(clk), .rst_n(rst_n),
        .set_valid(set_valid), .set_row(set_row), .set_idx(set_idx),
        .clr_valid(clr_valid), .clr_row(clr_row), .clr_idx(clr_idx),
        .alloc_req(alloc_req), .alloc_row(alloc_row),
        .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
        .free_vec(free_vec),
        .ckpt_take(ckpt_take), .ckpt_restore(ckpt_restore));

    function automatic logic [N-1:0] dec(input logic v, input int i);
        logic [N-1:0] m = '0;
        if (v && i > 0 && i < N) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [N-1:0] m_held();
        logic [N-1:0] h = '0;
        for (int r = 0; r < ROWS; r++) h = h | m_rows[r];
        return h;
    endfunction

    task automatic check_vec(input string tag, input logic [N-1:0] act,
                             input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int r = 0; r < ROWS; r++) m_rows[r] = '0;
        m_keep = '1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        set_valid = 0; clr_valid = 0; alloc_req = 0; ckpt_take = 0; ckpt_restore = 0;
        @(posedge clk);
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive one cycle, compare outputs with the model, then advance the model
    task automatic cycle(input logic sv, input int sr, input int si,
                         input logic cv, input int cr, input int ci,
                         input logic ar, input int arow,
                         input logic tk, input logic rs, input string tag);
        logic [N-1:0] held, fr, gm, setm, clrm, base;
        int low;
        logic vexp, g;
        @(negedge clk);
        set_valid = sv; set_row = ROW_W'(sr); set_idx = IDX_W'(si);
        clr_valid = cv; clr_row = ROW_W'(cr); clr_idx = IDX_W'(ci);
        alloc_req = ar; alloc_row = ROW_W'(arow);
        ckpt_take = tk; ckpt_restore = rs;
        #1;
        held = m_held();
        fr = ~held; fr[0] = 1'b0;
        low = 0;
        for (int p = N - 1; p >= 1; p--) if (fr[p]) low = p;
        vexp = (low != 0) && !rs;
        g = ar && vexp;
        gm = dec(g, low);
        check_int({tag, " alloc_valid"}, int'(alloc_valid), int'(vexp));
        if (vexp) check_int({tag, " alloc_idx"}, int'(alloc_idx), low);
        check_vec({tag, " free_vec"}, free_vec, fr & ~gm);
        last_valid = alloc_valid;
        @(posedge clk);
        for (int r = 0; r < ROWS; r++) begin
            base = rs ? (m_rows[r] & m_keep) : m_rows[r];
            setm = ((sr == r) ? dec(sv, si) : '0) | ((arow == r) ? gm : '0);
            clrm = (cr == r) ? dec(cv, ci) : '0;
            m_rows[r] = (base & ~clrm) | setm;
        end
        if (tk && !rs) m_keep = m_held();
    endtask

    task automatic idle(input string tag);
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000 && !done) begin
                bad++;
                total++;
                $display("FAIL watchdog: actual=%0d expected<=100000", cyc);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        do_reset();

        // R1: reset state
        idle("R1");
        check_vec("R1 free after reset", free_vec, ~(N'(1)));
        check_int("R1 first offer", int'(alloc_idx), 1);

        // R2, R3: two holders of register 5
        cycle(1, 1, 5, 0, 0, 0, 0, 0, 0, 0, "R2");
        cycle(1, 2, 5, 0, 0, 0, 0, 0, 0, 0, "R2");
        check_int("R2 held", int'(free_vec[5]), 0);
        cycle(0, 0, 0, 1, 1, 5, 0, 0, 0, 0, "R3");
        idle("R3");
        check_int("R3 still held by row 2", int'(free_vec[5]), 0);
        cycle(0, 0, 0, 1, 2, 5, 0, 0, 0, 0, "R3");
        idle("R3");
        check_int("R3 free after last holder", int'(free_vec[5]), 1);

        // R4: set and clear collide on row 3 / register 7
        cycle(1, 3, 7, 1, 3, 7, 0, 0, 0, 0, "R4");
        idle("R4");
        check_int("R4 set wins", int'(free_vec[7]), 0);

        // R8, R12: index 0 and out-of-range indices do nothing
        cycle(1, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R8");
        cycle(1, 4, 200, 0, 0, 0, 0, 0, 0, 0, "R12");
        idle("R12");
        check_int("R8 zero not free", int'(free_vec[0]), 0);
        check_vec("R12 no change", free_vec, ~(N'(1)) & ~(N'(1) << 7));

        // R5, R6, R9, R10, R11: snapshot then trim
        do_reset();
        cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R5");
        cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R6");
        cycle(0, 0, 0, 0, 0, 0, 1, 0, 1, 0, "R9");
        cycle(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R5");
        cycle(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R5");
        cycle(0, 0, 0, 1, 0, 2, 0, 0, 0, 0, "R10");
        cycle(0, 0, 0, 0, 0, 0, 1, 2, 0, 1, "R11");
        check_int("R11 no offer on restore", int'(last_valid), 0);
        idle("R10");
        check_vec("R10 trimmed", free_vec[5:0], 6'b110100);
        check_int("R10 next offer", int'(alloc_idx), 2);

        // R7: drain the pool
        do_reset();
        begin
            int grants = 0;
            for (int k = 0; k < N + 4; k++) begin
                cycle(0, 0, 0, 0, 0, 0, 1, k % ROWS, 0, 0, "R7");
                if (last_valid) grants++;
            end
            check_int("R7 grant count", grants, N - 1);
            check_int("R7 empty", int'(alloc_valid), 0);
            check_vec("R7 none free", free_vec, '0);
        end

        // mixed random traffic
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            cycle($urandom_range(0, 1) == 1, $urandom_range(0, ROWS - 1),
                  $urandom_range(0, N + 10),
                  $urandom_range(0, 2) != 0, $urandom_range(0, ROWS - 1),
                  $urandom_range(0, N + 10),
                  $urandom_range(0, 2) == 0, $urandom_range(0, ROWS - 1),
                  $urandom_range(0, 15) == 0, $urandom_range(0, 63) == 0,
                  "R3 R5 R10 random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule